// File: doc/BRIEF.md
# Vector-Table Interrupt Capability Registers

This block is the configuration-space capability structure for a message-signalled interrupt vector table. The structure is twelve bytes long. It holds a read-only identifier byte, a pointer to the next capability, a 16-bit control word and two read-only locator dwords. The first locator dword points at the vector table and the second at the pending-bit array, and both carry the BAR index in their low bits. The control word reports the table size, which is fixed by a parameter. Only its two top bits can be written: a global enable and a function-wide mask. Both bits drive outputs to the vector table logic.

Configuration writes and reads arrive as 1, 2 or 4 bytes, little-endian, at a byte offset relative to the start of the capability. A write is applied one byte at a time at increasing offsets. Software can unmask or enable the function. When a write does either, the block sends a single-cycle rescan pulse to the vector table block, which then re-examines every pending vector.

Top module: `vtcap_regs`

## Requirements
- R1: After reset, `msg_enable`, `func_mask` and `rescan` are all 0.
- R2: Offset 0 reads the parameter CAP_ID and offset 1 reads NEXT_PTR. Writes to either byte have no effect.
- R3: Control-word bits 10:0 (offsets 2 and 3) read N_VEC-1 and bits 13:11 read 0. All 14 of these bits ignore writes.
- R4: Control bit 15 (bit 7 of offset 3) is the enable and bit 14 (bit 6 of offset 3) is the mask. Each takes the written value and appears on `msg_enable` / `func_mask` one cycle after the write.
- R5: A write of length 1, 2 or 4 at offset o puts `wr_data` bits 8k+7:8k at offset o+k. A write of any other length changes nothing.
- R6: Offsets 4..7 read as the dword BAR_IDX, and offsets 8..11 read as the dword 0x800|BAR_IDX. Offsets from 12 upward read 0. None of these bytes can be written.
- R7: `rescan` is high for exactly the one cycle after a write that changes the mask from 1 to 0.
- R8: `rescan` is also high for the one cycle after a write that changes the enable from 0 to 1 and leaves the mask 0. It is never high otherwise.
- R9: A read of length 1, 2 or 4 returns the bytes at offsets o..o+len-1 in little-endian order. Unused upper bytes are zero, and any other length returns 0.
- R10: A write that meets both the R7 and R8 conditions still gives one single-cycle pulse.
- R11: N_VEC must lie in 1..2048 and BAR_IDX in 0..5, or elaboration fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Config write strobe |
| wr_off | input | 8 | Write byte offset within the capability |
| wr_len | input | 3 | Write length in bytes (1, 2, 4) |
| wr_data | input | 32 | Write data, lowest byte first |
| rd_off | input | 8 | Read byte offset within the capability |
| rd_len | input | 3 | Read length in bytes (1, 2, 4) |
| rd_data | output | 32 | Read data, combinational |
| msg_enable | output | 1 | Global enable bit |
| func_mask | output | 1 | Function-wide mask bit |
| rescan | output | 1 | One-cycle request to rescan pending vectors |

## Verification
The hardest condition to reach is a write that reaches the writable control byte through a lane other than lane 0. Examples are a 4-byte write at offset 0, or a write starting at offset 1 whose third byte lands on offset 3. Such a write has to move the enable or mask in the direction that should fire the rescan. The stimulus sets the control bits up with directed single-byte writes first. It then uses wide, unaligned and odd-length writes, so that each transition arrives through each lane. After that comes a long pseudo-random run over offsets, lengths and data. Every cycle, that run is compared against a behavioural byte model of the capability.

// File: rtl/vtcap_pkg.sv
package vtcap_pkg;

    localparam int unsigned CAP_BYTES  = 12;
    localparam int unsigned LANES      = 4;
    localparam int unsigned ADDR_W     = 9;
    localparam int unsigned CTRL_HI    = 3;
    localparam int unsigned SIZE_W     = 11;
    localparam int unsigned MAX_VEC    = 2048;
    localparam int unsigned MAX_BAR    = 5;
    localparam logic [31:0] PEND_BASE  = 32'h0000_0800;
    localparam logic [31:0] TABLE_BASE = 32'h0000_0000;

    typedef struct packed {
        logic en;
        logic mask;
    } ctrl_bits_t;

    typedef struct packed {
        logic       hit;
        ctrl_bits_t val;
    } ctrl_upd_t;

    function automatic logic len_legal(input logic [2:0] len);
        return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    endfunction

    function automatic logic lane_live(input logic [2:0] len, input int unsigned lane);
        return len_legal(len) && (lane < int'(len));
    endfunction

    function automatic logic [ADDR_W-1:0] lane_addr(input logic [7:0] base,
                                                    input int unsigned lane);
        return {1'b0, base} + ADDR_W'(lane);
    endfunction

endpackage

// File: rtl/vtcap_wr_walk.sv
module vtcap_wr_walk
    import vtcap_pkg::*;
(
    input  logic        wr_en,
    input  logic [7:0]  wr_off,
    input  logic [2:0]  wr_len,
    input  logic [31:0] wr_data,
    output ctrl_upd_t   upd
);
    logic       lane_hit [LANES];
    ctrl_bits_t lane_val [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] addr;
        logic [7:0]        dbyte;
        assign addr  = lane_addr(wr_off, k);
        assign dbyte = wr_data[8*k +: 8];
        assign lane_hit[k] = wr_en && lane_live(wr_len, k) && (addr == ADDR_W'(CTRL_HI));
        assign lane_val[k] = '{en: dbyte[7], mask: dbyte[6]};
    end

    // Byte walk at rising addresses: a later lane overrides an earlier one.
    always_comb begin
        upd = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_hit[k]) begin
                upd.hit = 1'b1;
                upd.val = lane_val[k];
            end
        end
    end

endmodule

// File: rtl/vtcap_ctrl.sv
module vtcap_ctrl
    import vtcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_upd_t  upd,
    output ctrl_bits_t ctrl_q,
    output logic       rescan_q
);
    logic unmask_now;
    logic enable_now;

    assign unmask_now = ctrl_q.mask && !upd.val.mask;
    assign enable_now = !ctrl_q.en && upd.val.en && !upd.val.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rescan_q <= 1'b0;
        end else begin
            rescan_q <= 1'b0;
            if (upd.hit) begin
                ctrl_q   <= upd.val;
                rescan_q <= unmask_now || enable_now;
            end
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q)); // R4

    AST_RESCAN_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        rescan_q |-> !ctrl_q.mask); // R7

    AST_RESCAN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rescan_q |-> (($past(ctrl_q.mask) && !ctrl_q.mask) ||
                      (!$past(ctrl_q.en) && ctrl_q.en))); // R8

    AST_RESCAN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        rescan_q |-> $past(wr_en)); // R10

endmodule

// File: rtl/vtcap_rd_mux.sv
module vtcap_rd_mux
    import vtcap_pkg::*;
#(
    parameter int unsigned N_VEC    = 16,
    parameter int unsigned BAR_IDX  = 0,
    parameter logic [7:0]  NEXT_PTR = 8'h00,
    parameter logic [7:0]  CAP_ID   = 8'h11
) (
    input  ctrl_bits_t  ctrl,
    input  logic [7:0]  rd_off,
    input  logic [2:0]  rd_len,
    output logic [31:0] rd_data
);
    localparam logic [SIZE_W-1:0] SIZE_M1 = SIZE_W'(N_VEC - 1);
    localparam logic [31:0]       TBL_DW  = TABLE_BASE | 32'(BAR_IDX);
    localparam logic [31:0]       PEND_DW = PEND_BASE  | 32'(BAR_IDX);

    function automatic logic [7:0] image_byte(input logic [ADDR_W-1:0] a,
                                              input ctrl_bits_t c);
        logic [7:0] b;
        case (a)
            9'd0:    b = CAP_ID;
            9'd1:    b = NEXT_PTR;
            9'd2:    b = SIZE_M1[7:0];
            9'd3:    b = {c.en, c.mask, 3'b000, SIZE_M1[10:8]};
            9'd4:    b = TBL_DW[7:0];
            9'd5:    b = TBL_DW[15:8];
            9'd6:    b = TBL_DW[23:16];
            9'd7:    b = TBL_DW[31:24];
            9'd8:    b = PEND_DW[7:0];
            9'd9:    b = PEND_DW[15:8];
            9'd10:   b = PEND_DW[23:16];
            9'd11:   b = PEND_DW[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_data[8*k +: 8] = lane_live(rd_len, k)
                                 ? image_byte(lane_addr(rd_off, k), ctrl) : 8'h00;
    end

endmodule

// File: rtl/vtcap_regs.sv
module vtcap_regs
    import vtcap_pkg::*;
#(
    parameter int unsigned N_VEC    = 16,
    parameter int unsigned BAR_IDX  = 0,
    parameter logic [7:0]  NEXT_PTR = 8'h00,
    parameter logic [7:0]  CAP_ID   = 8'h11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_off,
    input  logic [2:0]  wr_len,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_off,
    input  logic [2:0]  rd_len,
    output logic [31:0] rd_data,
    output logic        msg_enable,
    output logic        func_mask,
    output logic        rescan
);
    // R11: parameter range checked at elaboration
    if (N_VEC < 1 || N_VEC > MAX_VEC) begin : g_bad_count
        $error("vtcap_regs: N_VEC out of range");
    end
    if (BAR_IDX > MAX_BAR) begin : g_bad_bar
        $error("vtcap_regs: BAR_IDX out of range");
    end

    ctrl_upd_t  upd;
    ctrl_bits_t ctrl_q;

    vtcap_wr_walk u_walk (
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_len  (wr_len),
        .wr_data (wr_data),
        .upd     (upd)
    );

    vtcap_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .upd      (upd),
        .ctrl_q   (ctrl_q),
        .rescan_q (rescan)
    );

    vtcap_rd_mux #(
        .N_VEC    (N_VEC),
        .BAR_IDX  (BAR_IDX),
        .NEXT_PTR (NEXT_PTR),
        .CAP_ID   (CAP_ID)
    ) u_rd (
        .ctrl    (ctrl_q),
        .rd_off  (rd_off),
        .rd_len  (rd_len),
        .rd_data (rd_data)
    );

    assign msg_enable = ctrl_q.en;
    assign func_mask  = ctrl_q.mask;

    AST_RD_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_len != 3'd4) |-> (rd_data[31:16] == 16'h0000)); // R9

    AST_BAD_LEN_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !len_legal(wr_len)) |=> ($stable(msg_enable) && $stable(func_mask) && !rescan)); // R5

endmodule

// File: tb/vtcap_regs_tb.sv
module vtcap_regs_tb;
    localparam int unsigned NV  = 100;
    localparam int unsigned BAR = 3;
    localparam logic [7:0]  NXT = 8'h50;
    localparam logic [7:0]  CID = 8'h11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [2:0]  wr_len = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_off = '0;
    logic [2:0]  rd_len = '0;
    logic [31:0] rd_data;
    logic        msg_enable, func_mask, rescan;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit m_en = 0, m_mask = 0, m_pulse = 0;

    always #10 clk = ~clk;

    vtcap_regs #(.N_VEC(NV), .BAR_IDX(BAR), .NEXT_PTR(NXT), .CAP_ID(CID)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len),
        .wr_data(wr_data), .rd_off(rd_off), .rd_len(rd_len), .rd_data(rd_data),
        .msg_enable(msg_enable), .func_mask(func_mask), .rescan(rescan)
    );

    function automatic logic [7:0] model_byte(input int a);
        int ctrl = (int'(m_en) << 15) | (int'(m_mask) << 14) | (NV - 1);
        int pend = 'h800 | BAR;
        if (a == 0) return CID;
        if (a == 1) return NXT;
        if (a == 2 || a == 3) return 8'((ctrl >> (8 * (a - 2))) & 255);
        if (a >= 4 && a <= 7) return 8'((BAR >> (8 * (a - 4))) & 255);
        if (a >= 8 && a <= 11) return 8'((pend >> (8 * (a - 8))) & 255);
        return 8'h00;
    endfunction

    function automatic logic [31:0] model_read(input int off, input int len);
        logic [31:0] r = '0;
        if (len != 1 && len != 2 && len != 4) return r;
        for (int k = 0; k < len; k++) r[8*k +: 8] = model_byte(off + k);
        return r;
    endfunction

    task automatic model_write(input bit we, input int off, input int len, input logic [31:0] d);
        bit oe = m_en, om = m_mask;
        m_pulse = 0;
        if (!we || !(len == 1 || len == 2 || len == 4)) return;
        for (int k = 0; k < len; k++) begin
            if (off + k == 3) begin
                m_en   = d[8*k + 7];
                m_mask = d[8*k + 6];
            end
        end
        m_pulse = (om && !m_mask) || (!oe && m_en && !m_mask);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] wo, input logic [2:0] wl,
                        input logic [31:0] wd, input logic [7:0] ro, input logic [2:0] rl,
                        input string req);
        wr_en = we; wr_off = wo; wr_len = wl; wr_data = wd; rd_off = ro; rd_len = rl;
        #1;
        check(req, "rd_data", rd_data, model_read(int'(ro), int'(rl)));
        @(posedge clk);
        model_write(we, int'(wo), int'(wl), wd);
        @(negedge clk);
        wr_en = 1'b0;
        check(req, "msg_enable", 32'(msg_enable), 32'(m_en));
        check(req, "func_mask",  32'(func_mask),  32'(m_mask));
        check(req, "rescan",     32'(rescan),     32'(m_pulse));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "msg_enable", 32'(msg_enable), 0);
        check("R1", "func_mask",  32'(func_mask),  0);
        check("R1", "rescan",     32'(rescan),     0);
        // R2 identifier and pointer, read-only
        step(1, 8'd0, 3'd2, 32'hFFFF, 8'd0, 3'd2, "R2");
        step(0, 8'd0, 3'd1, 0, 8'd0, 3'd4, "R2");
        // R3 size field ignores writes
        step(1, 8'd2, 3'd1, 32'hFF, 8'd2, 3'd2, "R3");
        step(1, 8'd3, 3'd1, 32'h3F, 8'd2, 3'd2, "R3");
        // R4 set both bits: enable rises but mask set -> no pulse (R8)
        step(1, 8'd3, 3'd1, 32'hC0, 8'd2, 3'd2, "R4");
        // R7 unmask -> pulse
        step(1, 8'd3, 3'd1, 32'h80, 8'd3, 3'd1, "R7");
        // R8 disable (no pulse), then enable with mask clear (pulse)
        step(1, 8'd3, 3'd1, 32'h00, 8'd3, 3'd1, "R8");
        step(1, 8'd3, 3'd1, 32'h80, 8'd3, 3'd1, "R8");
        step(1, 8'd3, 3'd1, 32'h80, 8'd3, 3'd1, "R8");
        // R10 both causes in one write: mask 1->0 and enable 0->1
        step(1, 8'd3, 3'd1, 32'h40, 8'd3, 3'd1, "R10");
        step(1, 8'd3, 3'd1, 32'h80, 8'd2, 3'd2, "R10");
        // R5 lanes: 2-byte at 2, 4-byte at 0, 4-byte at 1, odd length ignored
        step(1, 8'd2, 3'd2, 32'h0000_40AA, 8'd2, 3'd2, "R5");
        step(1, 8'd0, 3'd4, 32'h0000_0000, 8'd0, 3'd4, "R5");
        step(1, 8'd1, 3'd4, 32'h00C0_0000, 8'd0, 3'd4, "R5");
        step(1, 8'd3, 3'd3, 32'h0000_0080, 8'd2, 3'd2, "R5");
        step(1, 8'd0, 3'd4, 32'h8000_0000, 8'd2, 3'd2, "R5");
        // R6 locator dwords and unused space
        step(1, 8'd4, 3'd4, 32'hFFFF_FFFF, 8'd4, 3'd4, "R6");
        step(1, 8'd8, 3'd4, 32'hFFFF_FFFF, 8'd8, 3'd4, "R6");
        step(0, 8'd0, 3'd1, 0, 8'd12, 3'd4, "R6");
        step(1, 8'd254, 3'd4, 32'hFFFF_FFFF, 8'd254, 3'd4, "R6");
        // R9 read lengths and offsets
        step(0, 8'd0, 3'd1, 0, 8'd9, 3'd1, "R9");
        step(0, 8'd0, 3'd1, 0, 8'd9, 3'd2, "R9");
        step(0, 8'd0, 3'd1, 0, 8'd1, 3'd3, "R9");
        step(0, 8'd0, 3'd1, 0, 8'd10, 3'd4, "R9");
        // Random run against the model
        for (int i = 0; i < 2000; i++) begin
            logic [7:0]  wo = 8'($urandom_range(0, 13));
            logic [2:0]  wl = 3'($urandom_range(0, 5));
            logic [31:0] wd = $urandom;
            logic [7:0]  ro = 8'($urandom_range(0, 13));
            logic [2:0]  rl = 3'($urandom_range(0, 5));
            step(bit'($urandom_range(0, 1)), wo, wl, wd, ro, rl, "R9");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule